// File: doc/BRIEF.md
# Asynchronous SRAM Lane Controller

This block connects an internal clocked request bus to an external asynchronous static RAM of 64K words by 16 bits. A request carries an address, a write flag, 16 bits of write data and a two-bit lane mask. It is accepted with a valid/ready handshake. A read returns its data through a one-cycle response strobe. On the memory side the block drives the address, the byte-lane enables and the active-low chip, write and output enables. It also drives the data pins through a split output/enable/input arrangement, so the tri-state buffer can sit at the pad ring.

Every memory-side control comes from a register. The control lines therefore change only on clock edges and cannot glitch. The access lengths are worked out from picosecond minimums and the clock period, each rounded up to whole cycles. At the defaults (5 ns clock, 15 ns access, 10 ns write pulse, 15 ns write cycle) a read holds the memory for 3 cycles. A write takes 1 setup cycle, 2 write-pulse cycles and 1 hold cycle.

A controller state machine moves through six named states:
- `ST_IDLE`: the chip is deselected and `req_ready` is high.
- `ST_WSETUP`, `ST_WPULSE`, `ST_WHOLD`: the three phases of a write.
- `ST_RACCESS`: the read access window.
- `ST_RTURN`: the bus turnaround after a read.

The transitions are:
- `ST_IDLE` to `ST_WSETUP` on a write with a non-zero mask.
- `ST_IDLE` to `ST_RACCESS` on a read with a non-zero mask.
- `ST_IDLE` stays in `ST_IDLE` on a zero-mask request. A zero-mask read answers at once.
- `ST_WSETUP` to `ST_WPULSE` after one cycle.
- `ST_WPULSE` to `ST_WHOLD` when the pulse timer expires.
- `ST_WHOLD` to `ST_IDLE` after one cycle.
- `ST_RACCESS` to `ST_RTURN` when the access timer expires. The data is captured on this transition. If the turnaround count is 0, the transition goes straight to `ST_IDLE`.
- `ST_RTURN` to `ST_IDLE` when the turnaround timer expires.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the block holds `req_ready` high and `mem_dq_oe` low. It also holds `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` high, which keeps the memory powered down.
- R2: During a write, `mem_ce_n` is low and `mem_oe_n` stays high. The block drives the write data from one cycle before `mem_we_n` falls until one cycle after it rises.
- R3: Each write holds `mem_we_n` low for exactly WE_CYC consecutive cycles. WE_CYC is 2 at the defaults.
- R4: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly RD_CYC cycles, which is 3 at the defaults. `rsp_valid` is sampled high RD_CYC cycles after the acceptance edge and lasts one cycle.
- R5: The read data of an enabled lane is the memory value present on the last access cycle. A lane that is not enabled returns zero.
- R6: The lane mask has bit 1 for bits 15:8 (`mem_ub_n`) and bit 0 for bits 7:0 (`mem_lb_n`). A set mask bit drives that lane enable low, and a partial write changes only the enabled lanes.
- R7: A request with mask 00 never pulls `mem_ce_n` low. A zero-mask write leaves memory unchanged. A zero-mask read raises `rsp_valid` with zero data on the cycle right after acceptance.
- R8: Between the last cycle with `mem_oe_n` low and the next cycle with `mem_dq_oe` high, at least TA_CYC+1 quiet cycles pass. TA_CYC is 1 at the defaults.
- R9: A request is accepted only while `req_ready` is high, and `req_ready` stays low for the whole of a memory access. The response of a zero-mask read and the acceptance of the next request may fall in the same cycle.
- R10: `mem_addr` holds the requested address and stays stable for every cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data to the memory pins |
| mem_dq_oe | output | 1 | Pad driver enable for the data pins |
| mem_dq_in | input | 16 | Data from the memory pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |

## Verification
The zero-mask read answers in `ST_IDLE` without leaving it. Its `rsp_valid` pulse therefore shares a cycle with `req_ready` high, and a new request can be taken in that same cycle. The bench provokes this by issuing a zero-mask read and holding `req_valid` high with a real read on the very next cycle. It then judges three things:
- the null response carries zero data;
- `req_ready` is high alongside that response;
- one cycle later `req_ready` has dropped and `mem_ce_n` has fallen, showing the second request was taken without a lost cycle.

The read that follows must still return the stored word.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RACCESS = 3'd4,
        ST_RTURN   = 3'd5
    } ctl_state_e;

    // whole cycles needed to cover a minimum time, rounded up
    function automatic int ceil_cycles(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_fsm.sv
`timescale 1ns/1ps
module sram_lane_fsm
    import sram_lane_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int RD_CYC = 3,
    parameter int WE_CYC = 2,
    parameter int TA_CYC = 1,
    parameter int CNT_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_mask,
    input  logic [LANES-1:0] hold_mask,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             null_rd,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    input  logic             tmr_expired,
    output logic             rsp_valid,
    output logic             mem_ce_n,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [LANES-1:0] mem_be_n,
    output logic             mem_dq_oe
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'((TA_CYC > 0) ? TA_CYC - 1 : 0);

    ctl_state_e state_q, state_nx;
    logic [LANES-1:0] mask_nx;
    logic nx_write, nx_read;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    assign req_ready = (state_q == ST_IDLE);

    // next state and strobes
    always_comb begin
        state_nx = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        null_rd  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_mask == '0) begin
                        null_rd = !req_write;
                    end else if (req_write) begin
                        state_nx = ST_WSETUP;
                    end else begin
                        state_nx = ST_RACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_WSETUP: begin
                state_nx = ST_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = WE_LOAD;
            end
            ST_WPULSE: begin
                if (tmr_expired) begin
                    state_nx = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                state_nx = ST_IDLE;
            end
            ST_RACCESS: begin
                if (tmr_expired) begin
                    capture = 1'b1;
                    if (TA_CYC == 0) begin
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_RTURN;
                        tmr_load = 1'b1;
                        tmr_val  = TA_LOAD;
                    end
                end
            end
            ST_RTURN: begin
                if (tmr_expired) begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign mask_nx  = accept ? req_mask : hold_mask;
    assign nx_write = (state_nx == ST_WSETUP) || (state_nx == ST_WPULSE) || (state_nx == ST_WHOLD);
    assign nx_read  = (state_nx == ST_RACCESS);

    // registered memory-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            mem_ce_n  <= !(nx_write || nx_read);
            mem_we_n  <= !(state_nx == ST_WPULSE);
            mem_oe_n  <= !nx_read;
            mem_be_n  <= (nx_write || nx_read) ? ~mask_nx : '1;
            mem_dq_oe <= nx_write;
            rsp_valid <= capture || null_rd;
        end
    end

    logic [CNT_W:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run_q <= '0;
        end else if (!mem_we_n) begin
            we_run_q <= we_run_q + 1'b1;
        end else begin
            we_run_q <= '0;
        end
    end

    // R1
    idle_powerdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));
    // R2
    write_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
    // R2
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> $past(mem_we_n));
    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q == (CNT_W+1)'(WE_CYC)));
    // R4
    read_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));
    // R7
    lane_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !(&mem_be_n));
    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));
    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

endmodule

// File: rtl/sram_lane_datapath.sv
`timescale 1ns/1ps
module sram_lane_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic              capture,
    input  logic              null_rd,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata,
    output logic [LANES-1:0]  hold_mask,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [DATA_W-1:0] lane_bits;

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_wdata <= '0;
            hold_mask  <= '0;
        end else if (accept) begin
            hold_addr  <= req_addr;
            hold_wdata <= req_wdata;
            hold_mask  <= req_mask;
        end
    end

    // per-lane read capture, disabled lanes forced to zero
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= 8'h00;
            end else if (capture) begin
                lane_q <= hold_mask[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
            end else if (null_rd) begin
                lane_q <= 8'h00;
            end
        end
        assign rsp_rdata[g*8 +: 8] = lane_q;
        assign lane_bits[g*8 +: 8] = {8{hold_mask[g]}};
    end

    // R5
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_rdata & ~lane_bits) == '0));

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int CLK_PS      = 5000,
    parameter int T_ACC_PS    = 15000,
    parameter int T_WPULSE_PS = 10000,
    parameter int T_WCYCLE_PS = 15000,
    parameter int TA_CYC      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);

    localparam int LANES  = DATA_W / 8;
    localparam int RD_CYC = imax(1, ceil_cycles(T_ACC_PS, CLK_PS));
    localparam int WP_CYC = imax(1, ceil_cycles(T_WPULSE_PS, CLK_PS));
    localparam int WC_CYC = ceil_cycles(T_WCYCLE_PS, CLK_PS);
    localparam int WE_CYC = imax(WP_CYC, WC_CYC - 2);
    localparam int CNT_W  = imax(1, $clog2(imax(imax(RD_CYC, WE_CYC), TA_CYC) + 1));

    logic             accept, capture, null_rd;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic [LANES-1:0] hold_mask, be_n;

    sram_lane_fsm #(
        .LANES  (LANES),
        .RD_CYC (RD_CYC),
        .WE_CYC (WE_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_mask    (req_mask),
        .hold_mask   (hold_mask),
        .req_ready   (req_ready),
        .accept      (accept),
        .capture     (capture),
        .null_rd     (null_rd),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_expired (tmr_expired),
        .rsp_valid   (rsp_valid),
        .mem_ce_n    (mem_ce_n),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_be_n    (be_n),
        .mem_dq_oe   (mem_dq_oe)
    );

    sram_cyc_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_lane_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .capture    (capture),
        .null_rd    (null_rd),
        .rsp_valid  (rsp_valid),
        .mem_dq_in  (mem_dq_in),
        .hold_addr  (mem_addr),
        .hold_wdata (mem_dq_out),
        .hold_mask  (hold_mask),
        .rsp_rdata  (rsp_rdata)
    );

    assign mem_ub_n = be_n[LANES-1];
    assign mem_lb_n = be_n[0];

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    // R6
    lane_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_ub_n) |-> hold_mask[1]);

endmodule

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

    localparam int RD_EXP = 3;
    localparam int WE_EXP = 2;
    localparam int TA_EXP = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid, mem_dq_oe;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
    );

    // memory model: 256 words, address bits 7:0
    logic [15:0] mdl [0:255];
    initial for (int i = 0; i < 256; i++) mdl[i] = 16'h0000;

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  = mem_dq_oe ? mem_dq_out[7:0]  : 8'hDD;
            if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] = mem_dq_oe ? mem_dq_out[15:8] : 8'hDD;
        end
    end

    always_comb begin
        mem_dq_in = 16'hEEEE;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = mdl[mem_addr[7:0]][7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = mdl[mem_addr[7:0]][15:8];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // protocol monitor
    int  ce_low_cnt = 0, we_run = 0, oe_run = 0, quiet = 0;
    bit  after_rd = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) ce_low_cnt++;
            if (!mem_we_n) begin
                we_run++;
                chk("R2 oe_n high while writing", int'(mem_oe_n), 1);
            end else if (we_run != 0) begin
                chk("R3 we_n pulse width", we_run, WE_EXP);
                chk("R2 data still driven after we_n rise", int'(mem_dq_oe), 1);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin
                chk("R4 read window length", oe_run, RD_EXP);
                oe_run = 0;
            end
            if (!mem_oe_n) begin
                quiet = 0;
                after_rd = 1;
            end else if (mem_dq_oe) begin
                if (after_rd) chk("R8 quiet cycles before drive", int'(quiet >= TA_EXP + 1), 1);
                after_rd = 0;
            end else begin
                quiet++;
            end
        end
    end

    task automatic do_req(input logic w, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] m, output int lat, output logic [15:0] rd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        rd  = '0;
        if (!w) begin
            while (!rsp_valid && lat < 50) begin
                @(negedge clk);
                lat++;
            end
            rd = rsp_rdata;
        end
    endtask

    // {write, addr, wdata, mask, expected}; mask bit1 = 15:8, bit0 = 7:0
    localparam logic [50:0] VEC [0:9] = '{
        {1'b1, 16'h0010, 16'hA5C3, 2'b11, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA5C3},
        {1'b1, 16'h0010, 16'h1234, 2'b01, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA534},
        {1'b1, 16'h0010, 16'h7E99, 2'b10, 16'h0000},
        {1'b0, 16'h0010, 16'h0000, 2'b01, 16'h0034},
        {1'b0, 16'h0010, 16'h0000, 2'b10, 16'h7E00},
        {1'b1, 16'h00FF, 16'h0F0F, 2'b11, 16'h0000},
        {1'b0, 16'h00FF, 16'h0000, 2'b11, 16'h0F0F},
        {1'b0, 16'h0010, 16'h0000, 2'b11, 16'h7E34}
    };

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        int          lat;
        logic [15:0] rd;
        int          ce_before;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 strobes {ce,we,oe,ub,lb}", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}), 5'h1F);
        chk("R1 dq_oe", int'(mem_dq_oe), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);

        for (int i = 0; i < 10; i++) begin
            do_req(VEC[i][50], VEC[i][49:34], VEC[i][33:18], VEC[i][17:16], lat, rd);
            if (!VEC[i][50]) begin
                chk("R4 read latency", lat, RD_EXP);
                chk("R5 R6 R10 read data", int'(rd), int'(VEC[i][15:0]));
            end
        end

        // R7 zero-mask requests touch nothing
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ce_before = ce_low_cnt;
        do_req(1'b1, 16'h0030, 16'hFFFF, 2'b00, lat, rd);
        do_req(1'b0, 16'h0030, 16'h0000, 2'b00, lat, rd);
        chk("R7 null read latency", lat, 0);
        chk("R7 null read data", int'(rd), 0);
        repeat (2) @(negedge clk);
        chk("R7 no chip select", ce_low_cnt - ce_before, 0);
        do_req(1'b0, 16'h0030, 16'h0000, 2'b11, lat, rd);
        chk("R7 null write left memory", int'(rd), 0);

        // R9 null response and next acceptance in the same cycle
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h00FF; req_mask = 2'b00;
        @(negedge clk);
        chk("R9 null rsp_valid", int'(rsp_valid), 1);
        chk("R9 ready with null rsp", int'(req_ready), 1);
        req_mask = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 next request taken", int'({req_ready, mem_ce_n}), 0);
        lat = 0;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 chained read data", int'(rsp_rdata), 16'h0F0F);

        repeat (4) @(negedge clk);
        chk("R1 idle after traffic", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'hE);
        report();
    end

endmodule